// File: doc/BRIEF.md
# Linked-list memory-to-stream DMA engine

This block runs the transmit side of one DMA channel. Software builds a chain of four-word data descriptors in memory and hands the engine the address of the first one together with the address of the enclosing context descriptor. The engine fetches each descriptor and reads the buffer it names through a word-wide memory master port. The buffer length comes from two pointers, the buffer start and the address one past the last byte. The engine sends the bytes one per beat on a valid/ready stream that carries a packet-end marker. A separate valid/ready sideband carries each packet's 16-bit metadata.

When a descriptor has been consumed, the engine writes its flags word back and can pulse an interrupt request. It then either follows the next pointer or, at end of list, marks the context descriptor disabled and halts. A resume pulse from the register unit makes a halted engine re-read its last descriptor. If software has since cleared that descriptor's end-of-list flag, the engine carries on along the chain.

Top module: `chain_tx_dma`

## Requirements
- R1: After a synchronous active-low reset the engine is idle: `busy_o`, `mem_req_o`, `st_valid_o`, `md_valid_o`, `irq_o` and `eol_o` are all low.
- R2: When `start_i` is seen while idle or halted, the engine reads four little-endian words at the head address and the next three word addresses. Word +0 is the next pointer, +4 the buffer start, +8 the flags and +12 the after address. In the flags word, bit 0 is end-of-list, bit 3 is packet end, bit 4 is interrupt, and bits 31:16 are metadata.
- R3: The engine streams the bytes from the buffer start up to the after address minus one, in ascending address order and at any alignment. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the memory word at a with its two low bits cleared.
- R4: Buffer reads are cut into bursts of at most `MAX_BURST` bytes. The byte stream runs on unchanged across burst boundaries.
- R5: `st_last_o` is high only on the final byte of a descriptor whose packet-end flag is set.
- R6: The metadata field is offered on `md_data_o` exactly once before the first byte of each packet. A packet starts at a start, at a restart after resume, and after any descriptor whose packet-end flag was set.
- R7: After a descriptor's final byte, its flags word is written back unchanged to descriptor address +8, before anything else happens for the next descriptor.
- R8: `irq_o` pulses for one cycle, in the cycle after the flags write-back is accepted, if and only if that descriptor's interrupt bit is set.
- R9: When end-of-list is clear, the next descriptor is loaded from the next pointer and streaming resumes from its buffer start.
- R10: When end-of-list is set, the engine reads context address +4 and writes that word back with bit 15 set. `eol_o` rises in the cycle after that write is accepted, and the engine halts.
- R11: A descriptor whose buffer start equals its after address produces no beats but still goes through write-back, interrupt and chaining.
- R12: `resume_i` is ignored unless the engine is halted at end of list. When halted, a resume re-reads the current descriptor. If its end-of-list flag is still set, the engine halts again with no output. Otherwise it follows the next pointer and starts a new packet. A start clears `eol_o`.
- R13: Once raised, `st_valid_o`, `md_valid_o` and `mem_req_o` stay high with stable data, address and direction until the handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a chain at `head_ptr_i` |
| head_ptr_i | input | AW | Address of the first data descriptor |
| ctx_ptr_i | input | AW | Address of the enclosing context descriptor |
| resume_i | input | 1 | Continue request from the register unit |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the request; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| st_valid_o | output | 1 | Stream byte valid |
| st_ready_i | input | 1 | Stream sink ready |
| st_data_o | output | 8 | Stream byte |
| st_last_o | output | 1 | Final byte of a packet |
| md_valid_o | output | 1 | Packet metadata valid |
| md_ready_i | input | 1 | Metadata accepted |
| md_data_o | output | 16 | Packet metadata |
| irq_o | output | 1 | Data interrupt request pulse |
| eol_o | output | 1 | Channel reached end of list |
| busy_o | output | 1 | Engine is walking the chain |

## Verification
Every result is tied to a handshake rather than to a fixed delay. Bytes, metadata and memory writes are due in the same cycle that their valid meets ready, because the stall patterns on all three ready inputs are free-running. The interrupt pulse is due exactly one cycle after the flags write-back is accepted, and `eol_o` one cycle after the context write. The bench compares every cycle against queues predicted from the descriptor chain in its memory model, so an early, late, missing or extra event fails. It also samples `irq_o` on every cycle against the write-back seen one cycle earlier.

// File: rtl/chain_tx_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the descriptor-chain transmit engine.
// Assumes 32-bit memory words and four-word data descriptors.
package chain_tx_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int META_W   = 16;
    // flags-word bit positions decoded from memory
    localparam int FL_EOL   = 0;
    localparam int FL_PEND  = 3;
    localparam int FL_IRQ   = 4;
    localparam int CTX_OFF  = 15;  // disable bit of the context flags word
    // descriptor word slots, in memory order
    localparam logic [1:0] DW_NEXT  = 2'd0;
    localparam logic [1:0] DW_BUF   = 2'd1;
    localparam logic [1:0] DW_FLAGS = 2'd2;
    localparam logic [1:0] DW_AFTER = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LOAD, ST_META, ST_SPAN, ST_FETCH,
        ST_BEAT, ST_WBACK, ST_CTX_RD, ST_CTX_WR, ST_HALT
    } eng_state_e;
endpackage

// File: rtl/chain_tx_span.sv
`timescale 1ns/1ps
// Computes the next burst length: bytes left up to the end pointer,
// capped at MAX_BURST. Assumes end_i >= ptr_i in a well-formed chain.
module chain_tx_span #(
    parameter int AW        = 32,
    parameter int MAX_BURST = 2048,
    parameter int BL_W      = 12
) (
    input  logic [AW-1:0]   ptr_i,
    input  logic [AW-1:0]   end_i,
    output logic [BL_W-1:0] len_o
);
    logic [AW-1:0] left;

    // remaining distance and clamp to the burst cap
    always_comb begin
        left  = end_i - ptr_i;
        len_o = (left > AW'(MAX_BURST)) ? BL_W'(MAX_BURST) : left[BL_W-1:0];
    end
endmodule

// File: rtl/chain_tx_lane.sv
`timescale 1ns/1ps
// Picks one byte lane of a little-endian memory word.
module chain_tx_lane #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = WORD_W / BYTE_W,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    // lane multiplexer
    always_comb byte_o = lane[sel_i];
endmodule

// File: rtl/chain_tx_dma.sv
`timescale 1ns/1ps
// Transmit engine for one DMA channel. It walks a linked list of four-word
// data descriptors, streams each buffer byte by byte, writes each consumed
// descriptor's flags back, and at end of list sets the disable bit of the
// context descriptor and halts.
// Assumes: the memory returns read data in the same cycle it accepts a
// request, and the buffer addresses of each descriptor are well formed.
module chain_tx_dma import chain_tx_pkg::*; #(
    parameter int AW        = 32,
    parameter int MAX_BURST = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [AW-1:0]     head_ptr_i,
    input  logic [AW-1:0]     ctx_ptr_i,
    input  logic              resume_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ready_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              st_valid_o,
    input  logic              st_ready_i,
    output logic [BYTE_W-1:0] st_data_o,
    output logic              st_last_o,
    output logic              md_valid_o,
    input  logic              md_ready_i,
    output logic [META_W-1:0] md_data_o,
    output logic              irq_o,
    output logic              eol_o,
    output logic              busy_o
);
    localparam int BL_W  = $clog2(MAX_BURST + 1);
    localparam int SEL_W = $clog2(WORD_W / BYTE_W);

    eng_state_e        state_q;
    logic [AW-1:0]     desc_q, next_q, ptr_q, after_q, ctx_q;
    logic [WORD_W-1:0] flags_q, word_q;
    logic [1:0]        widx_q;
    logic              reload_q, pkt_q, irq_q, eol_q;
    logic [BL_W-1:0]   burst_q, span_len;
    logic              mem_ack, tail;

    chain_tx_span #(.AW(AW), .MAX_BURST(MAX_BURST), .BL_W(BL_W)) u_span (
        .ptr_i (ptr_q),
        .end_i (after_q),
        .len_o (span_len)
    );

    chain_tx_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_lane (
        .word_i (word_q),
        .sel_i  (ptr_q[SEL_W-1:0]),
        .byte_o (st_data_o)
    );

    // memory request decode from the current state
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_LOAD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_q + AW'({widx_q, 2'b00});
            end
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {ptr_q[AW-1:SEL_W], SEL_W'(0)};
            end
            ST_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_q + AW'({DW_FLAGS, 2'b00});
                mem_wdata_o = flags_q;
            end
            ST_CTX_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ctx_q + AW'(4);
            end
            ST_CTX_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ctx_q + AW'(4);
                mem_wdata_o = word_q | (WORD_W'(1) << CTX_OFF);
            end
            default: ;
        endcase
    end

    // stream, metadata and status outputs
    always_comb begin
        mem_ack    = mem_req_o & mem_ready_i;
        tail       = (after_q - ptr_q) == AW'(1);
        st_valid_o = (state_q == ST_BEAT);
        st_last_o  = st_valid_o && flags_q[FL_PEND] && (burst_q == BL_W'(1)) && tail;
        md_valid_o = (state_q == ST_META);
        md_data_o  = flags_q[WORD_W-1 -: META_W];
        irq_o      = irq_q;
        eol_o      = eol_q;
        busy_o     = (state_q != ST_IDLE) && (state_q != ST_HALT);
    end

    // chain walker: descriptor load, bursts, write-back, end of list
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            desc_q   <= '0;
            next_q   <= '0;
            ptr_q    <= '0;
            after_q  <= '0;
            ctx_q    <= '0;
            flags_q  <= '0;
            word_q   <= '0;
            widx_q   <= '0;
            reload_q <= 1'b0;
            pkt_q    <= 1'b0;
            irq_q    <= 1'b0;
            eol_q    <= 1'b0;
            burst_q  <= '0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_HALT: begin
                    if (start_i) begin
                        desc_q   <= head_ptr_i;
                        ctx_q    <= ctx_ptr_i;
                        widx_q   <= DW_NEXT;
                        reload_q <= 1'b0;
                        pkt_q    <= 1'b1;
                        eol_q    <= 1'b0;
                        state_q  <= ST_LOAD;
                    end else if (state_q == ST_HALT && resume_i) begin
                        widx_q   <= DW_NEXT;
                        reload_q <= 1'b1;
                        state_q  <= ST_LOAD;
                    end
                end
                ST_LOAD: if (mem_ack) begin
                    widx_q <= widx_q + 2'd1;
                    unique case (widx_q)
                        DW_NEXT:  next_q  <= mem_rdata_i[AW-1:0];
                        DW_BUF:   ptr_q   <= mem_rdata_i[AW-1:0];
                        DW_FLAGS: flags_q <= mem_rdata_i;
                        default:  after_q <= mem_rdata_i[AW-1:0];
                    endcase
                    if (widx_q == DW_AFTER) begin
                        if (!reload_q) begin
                            state_q <= pkt_q ? ST_META : ST_SPAN;
                        end else if (flags_q[FL_EOL]) begin
                            reload_q <= 1'b0;
                            state_q  <= ST_HALT;
                        end else begin
                            reload_q <= 1'b0;
                            desc_q   <= next_q;
                            pkt_q    <= 1'b1;
                            eol_q    <= 1'b0;
                        end
                    end
                end
                ST_META: if (md_ready_i) begin
                    pkt_q   <= 1'b0;
                    state_q <= ST_SPAN;
                end
                ST_SPAN: begin
                    burst_q <= span_len;
                    state_q <= (span_len == '0) ? ST_WBACK : ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    word_q  <= mem_rdata_i;
                    state_q <= ST_BEAT;
                end
                ST_BEAT: if (st_ready_i) begin
                    ptr_q   <= ptr_q + AW'(1);
                    burst_q <= burst_q - BL_W'(1);
                    if (burst_q == BL_W'(1))
                        state_q <= tail ? ST_WBACK : ST_SPAN;
                    else if (&ptr_q[SEL_W-1:0])
                        state_q <= ST_FETCH;
                end
                ST_WBACK: if (mem_ack) begin
                    irq_q <= flags_q[FL_IRQ];
                    if (flags_q[FL_PEND]) pkt_q <= 1'b1;
                    if (flags_q[FL_EOL]) begin
                        state_q <= ST_CTX_RD;
                    end else begin
                        desc_q  <= next_q;
                        widx_q  <= DW_NEXT;
                        state_q <= ST_LOAD;
                    end
                end
                ST_CTX_RD: if (mem_ack) begin
                    word_q  <= mem_rdata_i;
                    state_q <= ST_CTX_WR;
                end
                ST_CTX_WR: if (mem_ack) begin
                    eol_q   <= 1'b1;
                    state_q <= ST_HALT;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/chain_tx_chk.sv
`timescale 1ns/1ps
// Protocol and ordering checks for chain_tx_dma, attached by bind.
module chain_tx_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid_o,
    input logic          st_ready_i,
    input logic [7:0]    st_data_o,
    input logic          st_last_o,
    input logic          md_valid_o,
    input logic          md_ready_i,
    input logic [15:0]   md_data_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic          mem_ready_i,
    input logic [AW-1:0] mem_addr_o,
    input logic [31:0]   mem_wdata_o,
    input logic          irq_o,
    input logic          eol_o,
    input logic          busy_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o && !st_valid_o && !md_valid_o); // R1
    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_valid_o, md_valid_o, mem_req_o})); // R2
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_data_o) && $stable(st_last_o)); // R13
    AST_META_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        md_valid_o && !md_ready_i |=> md_valid_o && $stable(md_data_o)); // R6
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R13
    AST_LAST_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        st_last_o |-> st_valid_o); // R5
    AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(mem_req_o && mem_we_o && mem_ready_i)); // R8
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R8
    AST_EOL_AFTER_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eol_o) |-> $past(mem_req_o && mem_we_o && mem_ready_i && mem_wdata_o[15])); // R10
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |-> !st_valid_o && !md_valid_o); // R12
endmodule

bind chain_tx_dma chain_tx_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid_o  (st_valid_o),
    .st_ready_i  (st_ready_i),
    .st_data_o   (st_data_o),
    .st_last_o   (st_last_o),
    .md_valid_o  (md_valid_o),
    .md_ready_i  (md_ready_i),
    .md_data_o   (md_data_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_ready_i (mem_ready_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .irq_o       (irq_o),
    .eol_o       (eol_o),
    .busy_o      (busy_o)
);

// File: tb/chain_tx_dma_bench.sv
`timescale 1ns/1ps
// Bench: a behavioural memory, an event prediction from the descriptor chain,
// and a per-clock comparison of every handshake and of the interrupt line.
module chain_tx_dma_bench;
    localparam int AW = 32;
    localparam int MB = 4;
    localparam logic [31:0] CTX = 32'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        start_i = 1'b0, resume_i = 1'b0;
    logic [31:0] head_ptr_i = '0;
    logic        mem_req_o, mem_we_o, mem_ready_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        st_valid_o, st_ready_i = 1'b0, st_last_o;
    logic [7:0]  st_data_o;
    logic        md_valid_o, md_ready_i = 1'b0;
    logic [15:0] md_data_o;
    logic        irq_o, eol_o, busy_o;

    logic [31:0] mem [0:255];
    assign mem_rdata_i = mem[mem_addr_o[9:2]];

    chain_tx_dma #(.AW(AW), .MAX_BURST(MB)) u_chain_tx_dma (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .head_ptr_i(head_ptr_i),
        .ctx_ptr_i(CTX), .resume_i(resume_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
        .st_valid_o(st_valid_o), .st_ready_i(st_ready_i), .st_data_o(st_data_o),
        .st_last_o(st_last_o), .md_valid_o(md_valid_o), .md_ready_i(md_ready_i),
        .md_data_o(md_data_o), .irq_o(irq_o), .eol_o(eol_o), .busy_o(busy_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [8:0]  q_beat [$];
    logic [15:0] q_md [$];
    logic [63:0] q_wr [$];
    logic        irq_due = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 7) & 255);
    endfunction

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        return mem[a[9:2]][8*a[1:0] +: 8];
    endfunction

    task automatic put_desc(input logic [31:0] d, input logic [31:0] nx, input logic [31:0] bf,
                            input logic [31:0] fl, input logic [31:0] af);
        mem[d[9:2]]         = nx;
        mem[d[9:2] + 8'd1]  = bf;
        mem[d[9:2] + 8'd2]  = fl;
        mem[d[9:2] + 8'd3]  = af;
    endtask

    // expected events of a chain walk, from the requirements
    task automatic predict(input logic [31:0] head, input bit pkt_in);
        logic [31:0] d;
        bit pkt;
        d = head;
        pkt = pkt_in;
        for (int g = 0; g < 16; g++) begin
            logic [31:0] nx, bf, fl, af;
            nx = mem[d[9:2]];
            bf = mem[d[9:2] + 8'd1];
            fl = mem[d[9:2] + 8'd2];
            af = mem[d[9:2] + 8'd3];
            if (pkt) q_md.push_back(fl[31:16]);
            for (logic [31:0] a = bf; a != af; a++)
                q_beat.push_back({fl[3] && (a + 1 == af), byte_at(a)});
            q_wr.push_back({d + 32'd8, fl});
            pkt = fl[3];
            if (fl[0]) begin
                q_wr.push_back({CTX + 32'd4, mem[CTX[9:2] + 8'd1] | 32'h8000});
                break;
            end
            d = nx;
        end
    endtask

    // per-clock comparison; ready patterns change here, handshakes land on the next edge
    always @(negedge clk) begin
        logic due_n;
        logic [63:0] e;
        cyc++;
        st_ready_i  = (cyc % 3) != 1;
        mem_ready_i = (cyc % 4) != 2;
        md_ready_i  = (cyc % 2) == 0;
        if (rst_n) begin
            if (irq_o || irq_due) check(irq_o == irq_due, "R8 irq pulse", 64'(irq_o), 64'(irq_due));
            due_n = 1'b0;
            if (st_valid_o && st_ready_i) begin
                if (q_beat.size() == 0) check(0, "R3 R5 unexpected beat", {st_last_o, st_data_o}, 0);
                else begin
                    e = 64'(q_beat.pop_front());
                    check({st_last_o, st_data_o} == e[8:0], "R3 R4 R5 beat", {st_last_o, st_data_o}, e);
                end
            end
            if (md_valid_o && md_ready_i) begin
                if (q_md.size() == 0) check(0, "R6 unexpected metadata", md_data_o, 0);
                else begin
                    e = 64'(q_md.pop_front());
                    check(md_data_o == e[15:0], "R6 metadata", md_data_o, e);
                end
            end
            if (mem_req_o && mem_we_o && mem_ready_i) begin
                if (q_wr.size() == 0) check(0, "R7 R10 unexpected write", {mem_addr_o, mem_wdata_o}, 0);
                else begin
                    e = q_wr.pop_front();
                    check({mem_addr_o, mem_wdata_o} == e, "R7 R10 write", {mem_addr_o, mem_wdata_o}, e);
                end
                mem[mem_addr_o[9:2]] = mem_wdata_o;
                if (mem_addr_o != CTX + 32'd4) due_n = mem_wdata_o[4];
            end
            irq_due = due_n;
        end
    end

    task automatic pulse_start(input logic [31:0] h);
        @(negedge clk);
        head_ptr_i = h;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_resume();
        @(negedge clk);
        resume_i = 1'b1;
        @(negedge clk);
        resume_i = 1'b0;
    endtask

    task automatic wait_settle(input int lim);
        int n;
        n = 0;
        repeat (4) @(negedge clk);
        while (busy_o && n < lim) begin
            @(negedge clk);
            n++;
        end
        if (n >= lim) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: engine still busy actual=1 expected=0");
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic drained(input string tag);
        check(q_beat.size() == 0 && q_md.size() == 0 && q_wr.size() == 0, tag,
              64'(q_beat.size() + q_md.size() + q_wr.size()), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++)
            mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
        mem[CTX[9:2] + 8'd1] = 32'h0000_0081;
        // chain: unaligned 10 bytes with irq, empty packet end, eop + end of list
        put_desc(32'h100, 32'h110, 32'h201, 32'h1A2B_0810, 32'h20B);
        put_desc(32'h110, 32'h120, 32'h230, 32'h3C4D_0018, 32'h230);
        put_desc(32'h120, 32'h130, 32'h242, 32'h5E6F_0009, 32'h247);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !mem_req_o && !st_valid_o && !md_valid_o, "R1 idle after reset",
              {busy_o, mem_req_o, st_valid_o, md_valid_o}, 0);
        check(!eol_o && !irq_o, "R1 flags after reset", {eol_o, irq_o}, 0);

        // R12 resume while idle is ignored
        pulse_resume();
        repeat (20) @(negedge clk);
        check(!busy_o && !mem_req_o, "R12 resume ignored when idle", {busy_o, mem_req_o}, 0);

        // R2 R9 R11 main chain
        predict(32'h100, 1'b1);
        pulse_start(32'h100);
        wait_settle(3000);
        drained("R9 R11 chain events complete");
        check(eol_o == 1'b1, "R10 eol raised at end of list", 64'(eol_o), 1);
        check(mem[CTX[9:2] + 8'd1][15] == 1'b1, "R10 context disable bit", mem[CTX[9:2] + 8'd1], 32'h8081);

        // R12 resume with end of list still set: reload only, halt again
        pulse_resume();
        wait_settle(500);
        drained("R12 no output while still at end of list");
        check(eol_o && !busy_o, "R12 halted again", {eol_o, busy_o}, 2);

        // R12 resume after clearing end of list: follow next pointer
        mem[32'h128 >> 2] = 32'h5E6F_0008;
        put_desc(32'h130, 32'h0, 32'h2F3, 32'h7788_0001, 32'h2F6);
        predict(32'h130, 1'b1);
        pulse_resume();
        wait_settle(3000);
        drained("R12 restart along chain");
        check(eol_o == 1'b1, "R10 eol after restarted chain", 64'(eol_o), 1);

        // R4 chunked long buffer, started from halt; start clears eol
        put_desc(32'h140, 32'h0, 32'h300, 32'h9ABC_0019, 32'h30B);
        predict(32'h140, 1'b1);
        pulse_start(32'h140);
        check(eol_o == 1'b0, "R12 start clears eol", 64'(eol_o), 0);
        wait_settle(3000);
        drained("R4 long buffer across bursts");
        check(eol_o && !busy_o, "R10 final halt", {eol_o, busy_o}, 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule